// File: doc/BRIEF.md
# Smart-Card Character Sniffing Receiver

This block is a passive, receive-only tap for a smart-card contact interface. It watches the card reset, card clock and bidirectional data line, each first brought into the fast system clock domain. It recovers every asynchronous character on the data line in either direction, because a tap cannot tell the two senders apart. It never drives the line, so it can only observe a receiver's error signal, never raise one.

Bit timing is measured in rising edges of the card clock, at a resolution of half an elementary time unit (half-etu). The half-etu count sits in a register:
- A rising edge of card reset loads the register with 186, the value for the default clock-to-baud ratio of 372.
- A load port can overwrite the register between characters, after a speed negotiation that a neighbouring block decodes.

For each character the block delivers a one-cycle valid strobe together with:
- the eight data bits, exactly as they arrived;
- the raw parity bit;
- a flag that shows an error signal was seen.

Each edge of card reset is reported as a separate one-cycle event that carries the new reset level.

Top module: `sc_sniff_rx`

## Requirements
- R1: Card reset, card clock and data each pass through a two-flop synchronizer, so all three get the same delay. A change on `card_rst_i` driven between clock edges shows on `rst_event_o` after exactly three rising edges of `clk`.
- R2: A rising edge of card reset pulses `rst_event_o` for one cycle with `rst_level_o` = 1. A falling edge pulses it for one cycle with `rst_level_o` = 0. `rst_level_o` keeps the level of the last event and is 0 after reset.
- R3: `half_etu_o` is 186 after system reset. It is reloaded to 186 in the same cycle that a rising reset event is reported.
- R4: When a rising reset edge and an external load take effect on the same clock edge, the reload to 186 wins.
- R5: When `half_etu_load_i` is high at a clock edge, `half_etu_o` takes `half_etu_val_i` on that edge. With no load and no rising reset edge, the register keeps its value.
- R6: A character starts on a high-to-low edge of the synchronized data line. With half-etu count H, the next card clock rises after the start edge are counted:
  - the start bit is sampled at rise H;
  - data bit k (k = 0..7) is sampled at rise (3+2k)·H;
  - parity is sampled at rise 19·H.
- R7: `char_data_o[k]` is the k-th data bit after the start bit, so the first bit arrives in bit 0. `char_parity_o` is the ninth bit, taken raw. No bit is inverted or reordered.
- R8: The data line is sampled again at rise 22·H. Low there gives `char_err_o` = 1, high gives 0.
- R9: If the start bit reads high at rise H, the receiver drops the character, returns to idle and produces no strobe.
- R10: `char_valid_o` is high for exactly one cycle. It rises three `clk` edges after the card clock rise numbered 22·H is driven on the input.
- R11: The half-etu count is captured at the start edge. A load during a character takes effect from the next character on.
- R12: After the error sample, a new start edge is not accepted until the data line has been seen high. A data line held low after the error window produces no extra character.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| card_rst_i | input | 1 | Card reset line, asynchronous |
| card_clk_i | input | 1 | Card clock line, asynchronous |
| card_io_i | input | 1 | Card data line, asynchronous, idles high |
| half_etu_load_i | input | 1 | Load strobe for the half-etu register |
| half_etu_val_i | input | 8 | Value to load into the half-etu register |
| half_etu_o | output | 8 | Current half-etu count |
| char_valid_o | output | 1 | One-cycle strobe for a received character |
| char_data_o | output | 8 | Data bits; bit 0 is the first bit received |
| char_parity_o | output | 1 | Raw parity bit |
| char_err_o | output | 1 | Error signal seen at 11 etu |
| rst_event_o | output | 1 | One-cycle strobe on a card reset edge |
| rst_level_o | output | 1 | Card reset level of the last event |

## Verification
Every path through the synchronizer costs three system clock edges:
- A reset edge driven between clock edges is sampled as an event on the third falling edge afterwards.
- The character strobe is due three edges after the bench drives the card clock rise numbered 22·H.

The bench records the cycle counter at the instant it drives those inputs and compares it with the cycle at which a monitor sees the strobe. The difference must be exactly 3. Register updates from the load port are due one edge after the load, so they are sampled at the following falling edge.

// File: rtl/sc_sniff_pkg.sv
package sc_sniff_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_BITS,
        RX_ERRCHK,
        RX_WAITHI
    } rx_state_e;

    // Half-etu index counter width and the indices at which the line is sampled
    localparam int          HALF_IDX_W    = 5;
    localparam logic [4:0]  HALF_START    = 5'd1;
    localparam logic [4:0]  HALF_LAST_BIT = 5'd19;
    localparam logic [4:0]  HALF_ERR      = 5'd22;

    // Character frame: 8 data bits plus parity
    localparam int          FRAME_BITS    = 9;

endpackage

// File: rtl/sc_sniff_sync.sv
module sc_sniff_sync #(
    parameter int           N        = 3,
    parameter logic [N-1:0] IDLE_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] prev_o
);

    typedef struct packed {
        logic [N-1:0] meta;
        logic [N-1:0] stab;
        logic [N-1:0] prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = raw_i;
        sync_d.stab = sync_q.meta;
        sync_d.prev = sync_q.stab;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '{meta: IDLE_VAL, stab: IDLE_VAL, prev: IDLE_VAL};
        end else begin
            sync_q <= sync_d;
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_out
        assign lvl_o[i]  = sync_q.stab[i];
        assign prev_o[i] = sync_q.prev[i];
    end

endmodule

// File: rtl/sc_sniff_rst_track.sv
module sc_sniff_rst_track #(
    parameter int           HALF_W   = 8,
    parameter logic [HALF_W-1:0] HALF_DEF = 8'd186
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl_i,
    input  logic              prev_i,
    input  logic              load_i,
    input  logic [HALF_W-1:0] val_i,
    output logic              evt_o,
    output logic              level_o,
    output logic [HALF_W-1:0] half_o
);

    typedef struct packed {
        logic              evt;
        logic              level;
        logic [HALF_W-1:0] half;
    } trk_t;

    trk_t trk_d, trk_q;
    logic rise, fall;

    always_comb begin
        rise      = lvl_i & ~prev_i;
        fall      = ~lvl_i & prev_i;
        trk_d     = trk_q;
        trk_d.evt = rise | fall;
        if (rise) begin
            trk_d.level = 1'b1;
        end else if (fall) begin
            trk_d.level = 1'b0;
        end
        // session-opening edge has priority over an external load
        if (rise) begin
            trk_d.half = HALF_DEF;
        end else if (load_i) begin
            trk_d.half = val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trk_q <= '{evt: 1'b0, level: 1'b0, half: HALF_DEF};
        end else begin
            trk_q <= trk_d;
        end
    end

    assign evt_o   = trk_q.evt;
    assign level_o = trk_q.level;
    assign half_o  = trk_q.half;

endmodule

// File: rtl/sc_sniff_char_rx.sv
module sc_sniff_char_rx
    import sc_sniff_pkg::*;
#(
    parameter int HALF_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_lvl_i,
    input  logic              io_prev_i,
    input  logic              cclk_lvl_i,
    input  logic              cclk_prev_i,
    input  logic [HALF_W-1:0] half_i,
    output logic              valid_o,
    output logic [7:0]        data_o,
    output logic              parity_o,
    output logic              err_o
);

    typedef struct packed {
        rx_state_e             st;
        logic [HALF_W-1:0]     cnt;
        logic [HALF_IDX_W-1:0] halfs;
        logic [HALF_W-1:0]     hetu;
        logic [FRAME_BITS-1:0] shreg;
        logic                  valid;
        logic [7:0]            data;
        logic                  par;
        logic                  err;
    } rx_t;

    rx_t rx_d, rx_q;

    logic                  io_fall;
    logic                  cclk_rise;
    logic [HALF_W:0]       cnt_inc;
    logic                  tick;
    logic [HALF_IDX_W-1:0] next_half;

    always_comb begin
        io_fall   = ~io_lvl_i & io_prev_i;
        cclk_rise = cclk_lvl_i & ~cclk_prev_i;
        cnt_inc   = {1'b0, rx_q.cnt} + 1'b1;
        tick      = cclk_rise && (cnt_inc >= {1'b0, rx_q.hetu});
        next_half = rx_q.halfs + 1'b1;

        rx_d       = rx_q;
        rx_d.valid = 1'b0;

        if (rx_q.st != RX_IDLE && cclk_rise) begin
            if (tick) begin
                rx_d.cnt   = '0;
                rx_d.halfs = next_half;
            end else begin
                rx_d.cnt = cnt_inc[HALF_W-1:0];
            end
        end

        case (rx_q.st)
            RX_IDLE: begin
                if (io_fall) begin
                    rx_d.st    = RX_START;
                    rx_d.cnt   = '0;
                    rx_d.halfs = '0;
                    rx_d.hetu  = half_i;
                end
            end
            RX_START: begin
                if (tick && next_half == HALF_START) begin
                    rx_d.st = io_lvl_i ? RX_IDLE : RX_BITS;
                end
            end
            RX_BITS: begin
                if (tick && next_half[0]) begin
                    rx_d.shreg = {io_lvl_i, rx_q.shreg[FRAME_BITS-1:1]};
                    if (next_half == HALF_LAST_BIT) begin
                        rx_d.st = RX_ERRCHK;
                    end
                end
            end
            RX_ERRCHK: begin
                if (tick && next_half == HALF_ERR) begin
                    rx_d.valid = 1'b1;
                    rx_d.data  = rx_q.shreg[7:0];
                    rx_d.par   = rx_q.shreg[FRAME_BITS-1];
                    rx_d.err   = ~io_lvl_i;
                    rx_d.st    = RX_WAITHI;
                end
            end
            RX_WAITHI: begin
                if (io_lvl_i) begin
                    rx_d.st = RX_IDLE;
                end
            end
            default: rx_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '{st: RX_IDLE, cnt: '0, halfs: '0, hetu: '0, shreg: '0,
                      valid: 1'b0, data: '0, par: 1'b0, err: 1'b0};
        end else begin
            rx_q <= rx_d;
        end
    end

    assign valid_o  = rx_q.valid;
    assign data_o   = rx_q.data;
    assign parity_o = rx_q.par;
    assign err_o    = rx_q.err;

endmodule

// File: rtl/sc_sniff_rx.sv
module sc_sniff_rx #(
    parameter int                HALF_W   = 8,
    parameter logic [HALF_W-1:0] HALF_DEF = 8'd186
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              card_rst_i,
    input  logic              card_clk_i,
    input  logic              card_io_i,
    input  logic              half_etu_load_i,
    input  logic [HALF_W-1:0] half_etu_val_i,
    output logic [HALF_W-1:0] half_etu_o,
    output logic              char_valid_o,
    output logic [7:0]        char_data_o,
    output logic              char_parity_o,
    output logic              char_err_o,
    output logic              rst_event_o,
    output logic              rst_level_o
);

    localparam int          N_LINES = 3;
    localparam int          IDX_RST = 0;
    localparam int          IDX_CLK = 1;
    localparam int          IDX_IO  = 2;
    localparam logic [N_LINES-1:0] LINE_IDLE = N_LINES'(1) << IDX_IO;

    logic [N_LINES-1:0] line_lvl;
    logic [N_LINES-1:0] line_prev;
    logic [N_LINES-1:0] line_raw;

    assign line_raw = {card_io_i, card_clk_i, card_rst_i};

    sc_sniff_sync #(
        .N        (N_LINES),
        .IDLE_VAL (LINE_IDLE)
    ) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (line_raw),
        .lvl_o  (line_lvl),
        .prev_o (line_prev)
    );

    sc_sniff_rst_track #(
        .HALF_W   (HALF_W),
        .HALF_DEF (HALF_DEF)
    ) rst_trk_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (line_lvl[IDX_RST]),
        .prev_i  (line_prev[IDX_RST]),
        .load_i  (half_etu_load_i),
        .val_i   (half_etu_val_i),
        .evt_o   (rst_event_o),
        .level_o (rst_level_o),
        .half_o  (half_etu_o)
    );

    sc_sniff_char_rx #(
        .HALF_W (HALF_W)
    ) char_rx_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .io_lvl_i    (line_lvl[IDX_IO]),
        .io_prev_i   (line_prev[IDX_IO]),
        .cclk_lvl_i  (line_lvl[IDX_CLK]),
        .cclk_prev_i (line_prev[IDX_CLK]),
        .half_i      (half_etu_o),
        .valid_o     (char_valid_o),
        .data_o      (char_data_o),
        .parity_o    (char_parity_o),
        .err_o       (char_err_o)
    );

endmodule

// File: rtl/sc_sniff_chk.sv
module sc_sniff_chk #(
    parameter int                HALF_W   = 8,
    parameter logic [HALF_W-1:0] HALF_DEF = 8'd186
) (
    input logic              clk,
    input logic              rst_n,
    input logic              half_etu_load_i,
    input logic [HALF_W-1:0] half_etu_val_i,
    input logic [HALF_W-1:0] half_etu_o,
    input logic              char_valid_o,
    input logic              rst_event_o,
    input logic              rst_level_o
);

    // R10: character strobe lasts a single cycle
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        char_valid_o |=> !char_valid_o);

    // R2: every reset event flips the reported level
    p_evt_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_event_o |-> (rst_level_o != $past(rst_level_o)));

    // R3 and R4: a rising reset event coincides with the default half-etu value
    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_event_o && rst_level_o) |-> (half_etu_o == HALF_DEF));

    // R5: a load lands on the next edge unless a session start overrides it
    p_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(half_etu_load_i) && !(rst_event_o && rst_level_o))
            |-> (half_etu_o == $past(half_etu_val_i)));

    // R5: with no load and no reset event the count holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(half_etu_load_i) && !rst_event_o) |-> $stable(half_etu_o));

endmodule

bind sc_sniff_rx sc_sniff_chk #(
    .HALF_W   (HALF_W),
    .HALF_DEF (HALF_DEF)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .half_etu_load_i (half_etu_load_i),
    .half_etu_val_i  (half_etu_val_i),
    .half_etu_o      (half_etu_o),
    .char_valid_o    (char_valid_o),
    .rst_event_o     (rst_event_o),
    .rst_level_o     (rst_level_o)
);

// File: tb/sc_sniff_rx_tb_top.sv
`timescale 1ns/1ps
module sc_sniff_rx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       card_rst = 1'b0;
    logic       card_clk = 1'b0;
    logic       card_io = 1'b1;
    logic       ld = 1'b0;
    logic [7:0] ld_val = 8'd0;
    logic [7:0] half_etu;
    logic       cv;
    logic [7:0] cdata;
    logic       cpar;
    logic       cerr;
    logic       revt;
    logic       rlvl;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int nvalid = 0;
    int vcyc   = 0;
    int ecyc   = 0;
    int dcyc   = 0;
    logic [7:0] got_data;
    logic       got_par;
    logic       got_err;

    always #4 clk = ~clk;

    sc_sniff_rx dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .card_rst_i      (card_rst),
        .card_clk_i      (card_clk),
        .card_io_i       (card_io),
        .half_etu_load_i (ld),
        .half_etu_val_i  (ld_val),
        .half_etu_o      (half_etu),
        .char_valid_o    (cv),
        .char_data_o     (cdata),
        .char_parity_o   (cpar),
        .char_err_o      (cerr),
        .rst_event_o     (revt),
        .rst_level_o     (rlvl)
    );

    // fields: half-etu[17:10], data[9:2], parity[1], error[0]
    localparam logic [17:0] VEC [0:7] = '{
        {8'd1,  8'hA5, 1'b0, 1'b0},
        {8'd2,  8'h3C, 1'b1, 1'b0},
        {8'd3,  8'h00, 1'b0, 1'b1},
        {8'd4,  8'hFF, 1'b1, 1'b0},
        {8'd5,  8'h81, 1'b1, 1'b1},
        {8'd7,  8'h5A, 1'b0, 1'b0},
        {8'd12, 8'hC3, 1'b1, 1'b1},
        {8'd16, 8'h7E, 1'b0, 1'b0}
    };

    initial begin
        forever @(posedge clk) cyc = cyc + 1;
    end

    initial begin
        forever @(negedge clk) card_clk = ~card_clk;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (cv) begin
                nvalid   = nvalid + 1;
                vcyc     = cyc;
                got_data = cdata;
                got_par  = cpar;
                got_err  = cerr;
            end
            if (revt) ecyc = cyc;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", cyc, 0);
        summary();
    end

    function automatic logic io_at(input int r, input int h, input logic [7:0] d,
                                   input logic p, input logic e, input int low_end);
        int k;
        if (r < 2*h) return 1'b0;
        if (r < 20*h) begin
            k = (r - 2*h) / (2*h);
            return (k == 8) ? p : d[k];
        end
        if (r < 21*h) return 1'b1;
        if (e && r < low_end*h) return 1'b0;
        return 1'b1;
    endfunction

    task automatic load_half(input logic [7:0] v);
        @(negedge clk);
        ld = 1'b1; ld_val = v;
        @(negedge clk);
        ld = 1'b0;
    endtask

    // Drives one character with half-etu h; optional load of mid_val during it
    task automatic send_char(input int h, input logic [7:0] d, input logic p,
                             input logic e, input int low_end,
                             input bit mid, input logic [7:0] mid_val);
        int last;
        last = (e ? low_end : 24) * h + 2;
        repeat (4) @(posedge card_clk);
        card_io = 1'b0;
        for (int r = 1; r <= last; r++) begin
            @(posedge card_clk);
            card_io = io_at(r, h, d, p, e, low_end);
            if (r == 22*h) dcyc = cyc;
            if (mid && r == 6*h) begin
                ld = 1'b1; ld_val = mid_val;
                @(negedge clk);
                ld = 1'b0;
            end
        end
        card_io = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic char_checks(input string tag, input int n0, input logic [7:0] d,
                               input logic p, input logic e);
        chk(nvalid == n0 + 1, {tag, " R10 strobe count"}, nvalid, n0 + 1);
        chk(got_data == d, {tag, " R7 data"}, got_data, d);
        chk(got_par == p, {tag, " R7 parity"}, got_par, p);
        chk(got_err == e, {tag, " R8 error flag"}, got_err, e);
        chk(vcyc - dcyc == 3, {tag, " R10 latency"}, vcyc - dcyc, 3);
    endtask

    initial begin
        int n0;
        int c0;
        logic [7:0] h_before;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk(half_etu == 8'd186, "R3 reset half-etu", half_etu, 186);
        chk(cv == 1'b0, "R10 reset strobe", cv, 0);
        chk(revt == 1'b0, "R2 reset event", revt, 0);
        chk(rlvl == 1'b0, "R2 reset level", rlvl, 0);

        load_half(8'd5);
        chk(half_etu == 8'd5, "R5 load", half_etu, 5);

        // card reset rise
        @(negedge clk);
        card_rst = 1'b1; c0 = cyc;
        repeat (3) @(negedge clk);
        chk(revt == 1'b1, "R2 rise event", revt, 1);
        chk(rlvl == 1'b1, "R2 rise level", rlvl, 1);
        chk(ecyc - c0 == 3, "R1 sync latency", ecyc - c0, 3);
        chk(half_etu == 8'd186, "R3 reload on rise", half_etu, 186);
        @(negedge clk);
        chk(revt == 1'b0, "R2 event one cycle", revt, 0);

        // character at the session default rate (R6)
        n0 = nvalid;
        send_char(186, 8'h96, 1'b1, 1'b0, 24, 1'b0, 8'd0);
        char_checks("R6 default rate", n0, 8'h96, 1'b1, 1'b0);

        // table of rates and patterns (R6, R7, R8)
        for (int i = 0; i < 8; i++) begin
            load_half(VEC[i][17:10]);
            chk(half_etu == VEC[i][17:10], "R5 table load", half_etu, VEC[i][17:10]);
            n0 = nvalid;
            send_char(int'(VEC[i][17:10]), VEC[i][9:2], VEC[i][1], VEC[i][0], 24, 1'b0, 8'd0);
            char_checks("R6 table", n0, VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // glitch on the line: start reads high at mid-point (R9)
        load_half(8'd4);
        n0 = nvalid;
        @(negedge clk); card_io = 1'b0;
        repeat (2) @(negedge clk); card_io = 1'b1;
        repeat (200) @(negedge clk);
        chk(nvalid == n0, "R9 glitch ignored", nvalid, n0);
        send_char(4, 8'h69, 1'b0, 1'b0, 24, 1'b0, 8'd0);
        char_checks("R9 recovery", n0, 8'h69, 1'b0, 1'b0);

        // load during a character applies only later (R11)
        n0 = nvalid;
        send_char(4, 8'h2D, 1'b1, 1'b0, 24, 1'b1, 8'd9);
        char_checks("R11 mid-load", n0, 8'h2D, 1'b1, 1'b0);
        chk(half_etu == 8'd9, "R11 new count held", half_etu, 9);

        // line held low long after error window (R12)
        load_half(8'd3);
        n0 = nvalid;
        send_char(3, 8'hB4, 1'b0, 1'b1, 40, 1'b0, 8'd0);
        char_checks("R12 long low", n0, 8'hB4, 1'b0, 1'b1);
        n0 = nvalid;
        send_char(3, 8'h1E, 1'b1, 1'b0, 24, 1'b0, 8'd0);
        char_checks("R12 next char", n0, 8'h1E, 1'b1, 1'b0);

        // card reset fall: event, level 0, count unchanged (R2, R5)
        h_before = half_etu;
        @(negedge clk);
        card_rst = 1'b0; c0 = cyc;
        repeat (3) @(negedge clk);
        chk(revt == 1'b1, "R2 fall event", revt, 1);
        chk(rlvl == 1'b0, "R2 fall level", rlvl, 0);
        chk(ecyc - c0 == 3, "R1 fall latency", ecyc - c0, 3);
        chk(half_etu == h_before, "R5 fall keeps count", half_etu, h_before);

        // rise with a simultaneous load: reload wins (R4)
        @(negedge clk);
        card_rst = 1'b1;
        repeat (2) @(negedge clk);
        ld = 1'b1; ld_val = 8'd7;
        @(negedge clk);
        ld = 1'b0;
        chk(revt == 1'b1 && rlvl == 1'b1, "R4 rise event", {revt, rlvl}, 3);
        chk(half_etu == 8'd186, "R4 reload beats load", half_etu, 186);

        repeat (5) @(negedge clk);
        summary();
    end

endmodule